// File: doc/BRIEF.md
# Load-Use Stall Unit

This unit sits in the decode stage of a five-stage in-order pipeline. It watches for a load in execute whose destination register is a source of the instruction currently in decode. The loaded word does not exist until the memory stage has finished, so forwarding cannot supply it in time. In that case the unit holds the program counter and the fetch/decode register for one cycle. It also replaces the memory-stage and write-back-stage control bits going into the decode/execute register with zeros. The result is a single harmless bubble, and forwarding from the later stage delivers the value on the next cycle.

The unit is purely combinational. Its outputs feed the write enables of the PC and the fetch/decode register, and its control multiplexer feeds the decode/execute register. Any dependence other than a load directly followed by its use is left to the forwarding path. The stall therefore drops as soon as the bubble (whose read-memory bit is zero) occupies decode/execute.

Top module: `load_use_stall`

## Requirements
- R1: When the execute-stage read-memory flag is 1, its target register is nonzero and equals the decode-stage first source register, `bubble_sel` is 1.
- R2: When the execute-stage read-memory flag is 1, its target register is nonzero and equals the decode-stage second source register, `bubble_sel` is 1.
- R3: When the execute-stage read-memory flag is 0, `bubble_sel` is 0 whatever the register numbers are.
- R4: A load targeting register 0 never causes a stall, even if register 0 is a source in decode.
- R5: `pc_we` and `ifid_we` are both 0 in a stall cycle and both 1 otherwise; `bubble_sel` is the inverse of `pc_we`.
- R6: In a stall cycle the memory group output `idex_m_ctl` (bit 2 branch, bit 1 read-memory, bit 0 write-memory) and the write-back group output `idex_wb_ctl` are all zero, and the execute group `idex_ex_ctl` equals `dec_ex_ctl`.
- R7: Outside a stall all three control groups pass from the `dec_*` inputs to the `idex_*` outputs unchanged.
- R8: In a pipeline, a load followed directly by a user of its target inserts exactly one bubble. The stall is raised for one cycle only, and the PC falls behind by exactly one.
- R9: In a pipeline, a load followed by one independent instruction and then a user of its target inserts no bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idex_memrd | input | 1 | Read-memory control bit held in decode/execute |
| idex_rt | input | REG_AW | Target register of the instruction in decode/execute |
| ifid_rs | input | REG_AW | First source register of the instruction in decode |
| ifid_rt | input | REG_AW | Second source register of the instruction in decode |
| dec_ex_ctl | input | EX_W | Execute-group control from the decoder |
| dec_m_ctl | input | M_W | Memory-group control from the decoder |
| dec_wb_ctl | input | WB_W | Write-back-group control from the decoder |
| pc_we | output | 1 | PC write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| bubble_sel | output | 1 | High when a bubble is being inserted |
| idex_ex_ctl | output | EX_W | Execute-group control into decode/execute |
| idex_m_ctl | output | M_W | Memory-group control into decode/execute |
| idex_wb_ctl | output | WB_W | Write-back-group control into decode/execute |

## Verification
The checks inside the unit are immediate and assume that every input is a defined value coming straight from pipeline registers. They are skipped while any input is unknown, which covers the span before the bench first drives them. The bench drives all inputs with blocking assignments at the falling clock edge and samples one time step later, so no check sees a partly updated set of inputs. In the pipeline scenarios the inputs come only from the bench's own register model. That model is loaded with fully defined instruction fields.

// File: rtl/load_use_stall.sv
module load_use_stall #(
  parameter int REG_AW = 5,
  parameter int EX_W   = 4,
  parameter int M_W    = 3,
  parameter int WB_W   = 2
) (
  input  logic              idex_memrd,
  input  logic [REG_AW-1:0] idex_rt,
  input  logic [REG_AW-1:0] ifid_rs,
  input  logic [REG_AW-1:0] ifid_rt,
  input  logic [EX_W-1:0]   dec_ex_ctl,
  input  logic [M_W-1:0]    dec_m_ctl,
  input  logic [WB_W-1:0]   dec_wb_ctl,
  output logic              pc_we,
  output logic              ifid_we,
  output logic              bubble_sel,
  output logic [EX_W-1:0]   idex_ex_ctl,
  output logic [M_W-1:0]    idex_m_ctl,
  output logic [WB_W-1:0]   idex_wb_ctl
);

  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic hit_rs, hit_rt, stall;

  always_comb begin
    hit_rs = (idex_rt == ifid_rs);
    hit_rt = (idex_rt == ifid_rt);
    stall  = idex_memrd && (idex_rt != ZERO_REG) && (hit_rs || hit_rt);

    bubble_sel = stall;
    pc_we      = !stall;
    ifid_we    = !stall;

    idex_ex_ctl = dec_ex_ctl;
    idex_m_ctl  = stall ? '0 : dec_m_ctl;
    idex_wb_ctl = stall ? '0 : dec_wb_ctl;

    if (!$isunknown({idex_memrd, idex_rt, ifid_rs, ifid_rt,
                     dec_ex_ctl, dec_m_ctl, dec_wb_ctl})) begin
      if (idex_memrd && idex_rt != ZERO_REG && idex_rt == ifid_rs)
        p_stall_on_rs_r1: assert (bubble_sel && !pc_we);
      if (idex_memrd && idex_rt != ZERO_REG && idex_rt == ifid_rt)
        p_stall_on_rt_r2: assert (bubble_sel && !ifid_we);
      if (!idex_memrd)
        p_no_load_r3: assert (!bubble_sel && pc_we && ifid_we);
      if (idex_rt == ZERO_REG)
        p_zero_reg_r4: assert (!bubble_sel);
      p_hold_pair_r5: assert (pc_we == ifid_we && bubble_sel == !pc_we);
      if (bubble_sel)
        p_bubble_clear_r6: assert (idex_m_ctl == '0 && idex_wb_ctl == '0
                                   && idex_ex_ctl == dec_ex_ctl);
      if (!bubble_sel)
        p_pass_thru_r7: assert (idex_m_ctl == dec_m_ctl && idex_wb_ctl == dec_wb_ctl
                                && idex_ex_ctl == dec_ex_ctl);
    end
  end

endmodule

// File: tb/load_use_stall_tb.sv
module load_use_stall_tb_top;
  localparam int CLK_P = 10;
  localparam int NPROG = 8;

  typedef struct packed {
    logic       ld;
    logic [4:0] rs;
    logic [4:0] rt;
  } ins_t;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic       idex_memrd;
  logic [4:0] idex_rt, ifid_rs, ifid_rt;
  logic [3:0] dec_ex_ctl, idex_ex_ctl;
  logic [2:0] dec_m_ctl, idex_m_ctl;
  logic [1:0] dec_wb_ctl, idex_wb_ctl;
  logic       pc_we, ifid_we, bubble_sel;

  int n_chk = 0;
  int n_bad = 0;

  load_use_stall dut_i (
    .idex_memrd(idex_memrd), .idex_rt(idex_rt), .ifid_rs(ifid_rs), .ifid_rt(ifid_rt),
    .dec_ex_ctl(dec_ex_ctl), .dec_m_ctl(dec_m_ctl), .dec_wb_ctl(dec_wb_ctl),
    .pc_we(pc_we), .ifid_we(ifid_we), .bubble_sel(bubble_sel),
    .idex_ex_ctl(idex_ex_ctl), .idex_m_ctl(idex_m_ctl), .idex_wb_ctl(idex_wb_ctl)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic mr, input logic [4:0] t, input logic [4:0] s1,
                       input logic [4:0] s2);
    @(negedge clk);
    idex_memrd = mr; idex_rt = t; ifid_rs = s1; ifid_rt = s2;
    dec_ex_ctl = 4'b1011; dec_m_ctl = 3'b111; dec_wb_ctl = 2'b11;
    #1;
  endtask

  task automatic t_reset_idle;
    drive(1'b0, 5'd0, 5'd0, 5'd0);
    check(pc_we && ifid_we && !bubble_sel, "R5 idle", {pc_we, ifid_we, bubble_sel}, 3'b110);
  endtask

  task automatic t_rs_match;
    drive(1'b1, 5'd7, 5'd7, 5'd3);
    check(bubble_sel == 1'b1, "R1", bubble_sel, 1);
    check({pc_we, ifid_we} == 2'b00, "R5 stall", {pc_we, ifid_we}, 0);
  endtask

  task automatic t_rt_match;
    drive(1'b1, 5'd31, 5'd2, 5'd31);
    check(bubble_sel == 1'b1, "R2", bubble_sel, 1);
  endtask

  task automatic t_no_load;
    drive(1'b0, 5'd9, 5'd9, 5'd9);
    check(bubble_sel == 1'b0 && pc_we, "R3", bubble_sel, 0);
    drive(1'b1, 5'd9, 5'd8, 5'd10);
    check(bubble_sel == 1'b0, "R3 no match", bubble_sel, 0);
  endtask

  task automatic t_zero_reg;
    drive(1'b1, 5'd0, 5'd0, 5'd0);
    check(bubble_sel == 1'b0 && ifid_we, "R4", bubble_sel, 0);
  endtask

  task automatic t_ctrl_mux;
    drive(1'b1, 5'd4, 5'd4, 5'd1);
    check(idex_m_ctl == 3'b000 && idex_wb_ctl == 2'b00, "R6 cleared",
          {idex_m_ctl, idex_wb_ctl}, 0);
    check(idex_ex_ctl == 4'b1011, "R6 ex kept", idex_ex_ctl, 4'b1011);
    drive(1'b1, 5'd4, 5'd5, 5'd6);
    check(idex_m_ctl == 3'b111 && idex_wb_ctl == 2'b11 && idex_ex_ctl == 4'b1011,
          "R7", {idex_ex_ctl, idex_m_ctl, idex_wb_ctl}, 9'b1011_111_11);
  endtask

  task automatic run_prog(input ins_t prog [NPROG], input int exp_bub, input string req);
    int   pc = 0;
    ins_t ifid = '0;
    logic r_mrd = 1'b0;
    logic [4:0] r_rt = 5'd0;
    int   bub = 0;
    int   consec = 0;
    int   max_run = 0;
    for (int cyc = 0; cyc < NPROG; cyc++) begin
      @(negedge clk);
      idex_memrd = r_mrd; idex_rt = r_rt;
      ifid_rs = ifid.rs; ifid_rt = ifid.rt;
      dec_ex_ctl = ifid.ld ? 4'b0011 : 4'b1100;
      dec_m_ctl  = {1'b0, ifid.ld, 1'b0};
      dec_wb_ctl = ifid.ld ? 2'b11 : 2'b01;
      #1;
      if (bubble_sel) begin bub++; consec++; end else consec = 0;
      if (consec > max_run) max_run = consec;
      @(posedge clk);
      r_mrd = idex_m_ctl[1];
      r_rt  = ifid.rt;
      if (ifid_we) ifid = (pc < NPROG) ? prog[pc] : '0;
      if (pc_we) pc++;
    end
    check(bub == exp_bub, {req, " bubbles"}, bub, exp_bub);
    check(max_run <= 1, {req, " stall length"}, max_run, 1);
    check(pc == NPROG - exp_bub, {req, " pc"}, pc, NPROG - exp_bub);
  endtask

  task automatic t_back_to_back;
    ins_t p [NPROG];
    foreach (p[i]) p[i] = '0;
    p[0] = '{ld: 1'b1, rs: 5'd2, rt: 5'd1};
    p[1] = '{ld: 1'b0, rs: 5'd1, rt: 5'd3};
    run_prog(p, 1, "R8");
    foreach (p[i]) p[i] = '0;
    p[0] = '{ld: 1'b1, rs: 5'd2, rt: 5'd6};
    p[1] = '{ld: 1'b1, rs: 5'd6, rt: 5'd7};
    run_prog(p, 1, "R8 load base");
  endtask

  task automatic t_separated;
    ins_t p [NPROG];
    foreach (p[i]) p[i] = '0;
    p[0] = '{ld: 1'b1, rs: 5'd2, rt: 5'd1};
    p[1] = '{ld: 1'b0, rs: 5'd5, rt: 5'd6};
    p[2] = '{ld: 1'b0, rs: 5'd1, rt: 5'd1};
    run_prog(p, 0, "R9");
    foreach (p[i]) p[i] = '0;
    p[0] = '{ld: 1'b1, rs: 5'd2, rt: 5'd0};
    p[1] = '{ld: 1'b0, rs: 5'd0, rt: 5'd0};
    run_prog(p, 0, "R4 pipeline");
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    t_reset_idle();
    t_rs_match();
    t_rt_match();
    t_no_load();
    t_zero_reg();
    t_ctrl_mux();
    t_back_to_back();
    t_separated();
    finish_run();
  end
endmodule